// File: doc/BRIEF.md
# Basic Block Loop Sequencer

This block walks a basic block one bundle at a time under the control of a block header. The header gives the block's start address, the number of bundles in the block, and how many times the block repeats. The repeat count comes from nowhere (single pass), from an immediate field, or from a count register whose index the header names. The register is read only in the cycle the header is accepted. The sequencer then issues one bundle address per cycle and restarts the block at its first bundle until every pass is done, so the loop needs no branch instruction.

A branch resolved in any bundle does not cut the block short. The sequencer records the branch and keeps issuing until the declared bundle count has gone out. When the final pass ends, the block emits a one-cycle completion pulse and the address where fetch continues. That address is the latest branch target recorded in the final pass, or the fall-through address just past the block when no branch was taken in that pass. The sequencer does not execute bundles and does not compute branch targets.

Top module: `bbs_loop_seq`

## Requirements
- R1: When `start` is high while the block is idle, the header is captured. On the next cycle `busy` and `bundle_valid` are high, with `bundle_idx` = 0, `iter_num` = 0 and `bundle_addr` = `hdr_base`.
- R2: Bundles issue one per cycle with no gaps. `bundle_addr` = base + `bundle_idx`, and `bundle_idx` runs from 0 to nb-1, where nb is `hdr_nb`. A `hdr_nb` of 0 is treated as one bundle.
- R3: `hdr_lsrc` selects the repeat count. 0 means a single pass, 1 means the count is `hdr_limm`, 2 means the count is `rf_data`, and 3 is treated as a single pass.
- R4: A repeat count of 0 or 1 runs the block exactly once.
- R5: `rf_idx` always equals `hdr_lreg`. `rf_data` is sampled only in the accepting cycle, and later changes to it do not alter the number of passes.
- R6: The block runs N passes back to back. After bundle nb-1, `bundle_idx` returns to 0 and `iter_num` increments by one, with no idle cycle in between.
- R7: A branch taken in any bundle, including bundle 0, does not stop issue. Every bundle of every pass is still issued.
- R8: The cycle after the final bundle of the final pass, `block_done` is high for exactly one cycle and `busy` and `bundle_valid` are low. If no branch was taken in the final pass, `next_pc` = base + nb.
- R9: If branches were taken in the final pass, `next_pc` is the target of the latest one. Branches taken in earlier passes, or while no bundle is valid, do not affect `next_pc`.
- R10: `start` asserted while the block is busy is ignored. The address sequence and `next_pc` of the running block are unchanged.
- R11: After reset, `busy`, `bundle_valid` and `block_done` are low and `next_pc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Header valid; accepted only when idle |
| hdr_base | input | ADDR_W | Address of bundle 0 |
| hdr_nb | input | NB_W | Bundles in the block (0 treated as 1) |
| hdr_lsrc | input | 2 | Repeat count source: 0 none, 1 immediate, 2 register, 3 none |
| hdr_limm | input | LC_W | Immediate repeat count |
| hdr_lreg | input | RIDX_W | Count register index |
| rf_idx | output | RIDX_W | Register read index (follows hdr_lreg) |
| rf_data | input | LC_W | Register read data |
| br_taken | input | 1 | Branch taken in the bundle currently issued |
| br_target | input | ADDR_W | Target of that branch |
| busy | output | 1 | Block is issuing bundles |
| bundle_valid | output | 1 | A bundle address is issued this cycle |
| bundle_addr | output | ADDR_W | Issued bundle address |
| bundle_idx | output | NB_W | Bundle index within the pass |
| iter_num | output | LC_W | Current pass number, from 0 |
| block_done | output | 1 | One-cycle pulse after the final bundle |
| next_pc | output | ADDR_W | Fetch address after the block |

## Verification
The hardest case to reach is the redirect decision at the final boundary. It needs a branch in an earlier pass that must be forgotten, a branch in bundle 0 of the last pass that must not stop issue, and two branches in the last pass where the later one must win. Directed blocks place taken branches at a chosen pass and bundle by driving `br_taken` on exactly the cycle that bundle is issued. Other directed blocks change `rf_data`, or raise `start` with a different header, in the middle of a run to show that neither disturbs the running block.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [1:0] {
        LSRC_NONE = 2'd0,
        LSRC_IMM  = 2'd1,
        LSRC_REG  = 2'd2,
        LSRC_RSVD = 2'd3
    } lsrc_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic running;
        logic last_bundle;
        logic last_iter;
    } seq_flags_t;

endpackage

// File: rtl/bbs_trip_sel.sv
module bbs_trip_sel #(
    parameter int LC_W = 8
) (
    input  logic [1:0]      lsrc,
    input  logic [LC_W-1:0] limm,
    input  logic [LC_W-1:0] rdata,
    output logic [LC_W-1:0] trips
);
    import bbs_pkg::*;

    localparam logic [LC_W-1:0] ONE = LC_W'(1);

    logic [LC_W-1:0] raw;

    always_comb begin
        case (lsrc_e'(lsrc))
            LSRC_IMM: raw = limm;
            LSRC_REG: raw = rdata;
            default:  raw = ONE;
        endcase
        trips = (raw <= ONE) ? ONE : raw;
    end

endmodule

// File: rtl/bbs_iter_ctrl.sv
module bbs_iter_ctrl #(
    parameter int NB_W = 3,
    parameter int LC_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic [NB_W-1:0]     nb_eff,
    input  logic [LC_W-1:0]     trips,
    output logic [NB_W-1:0]     idx,
    output logic [LC_W-1:0]     iter,
    output bbs_pkg::seq_flags_t flags
);
    import bbs_pkg::*;

    seq_state_e      state;
    logic [NB_W-1:0] nb_r;
    logic [LC_W-1:0] trips_r;

    always_comb begin
        flags.running     = (state == SEQ_RUN);
        flags.last_bundle = (idx == nb_r - NB_W'(1));
        flags.last_iter   = (iter == trips_r - LC_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            idx     <= '0;
            iter    <= '0;
            nb_r    <= NB_W'(1);
            trips_r <= LC_W'(1);
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        state   <= SEQ_RUN;
                        idx     <= '0;
                        iter    <= '0;
                        nb_r    <= nb_eff;
                        trips_r <= trips;
                    end
                end
                default: begin
                    if (flags.last_bundle) begin
                        idx <= '0;
                        if (flags.last_iter) begin
                            state <= SEQ_IDLE;
                            iter  <= '0;
                        end else begin
                            iter <= iter + LC_W'(1);
                        end
                    end else begin
                        idx <= idx + NB_W'(1);
                    end
                end
            endcase
        end
    end

    // Index stays inside the declared block length while issuing
    assert_idx_in_block_R2: assert property (@(posedge clk) disable iff (rst)
        flags.running |-> (idx < nb_r));

    // Pass boundary: index wraps and pass number steps without a gap
    assert_pass_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (flags.running && flags.last_bundle && !flags.last_iter)
        |=> (flags.running && idx == '0 && iter == $past(iter) + LC_W'(1)));

    // Mid-block bundles always advance by one
    assert_bundle_step_R7: assert property (@(posedge clk) disable iff (rst)
        (flags.running && !flags.last_bundle)
        |=> (flags.running && idx == $past(idx) + NB_W'(1)));

endmodule

// File: rtl/bbs_redirect.sv
module bbs_redirect #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              issue,
    input  logic              last_bundle,
    input  logic              last_iter,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [ADDR_W-1:0] fallthru,
    output logic              done,
    output logic [ADDR_W-1:0] next_pc
);
    logic              rec_vld;
    logic [ADDR_W-1:0] rec_tgt;
    logic              br_now;
    logic              pass_end;

    assign br_now   = issue && br_taken;
    assign pass_end = issue && last_bundle;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_vld <= 1'b0;
            rec_tgt <= '0;
            done    <= 1'b0;
            next_pc <= '0;
        end else begin
            done <= 1'b0;
            if (accept || pass_end) begin
                rec_vld <= 1'b0;
            end else if (br_now) begin
                rec_vld <= 1'b1;
                rec_tgt <= br_target;
            end
            if (pass_end && last_iter) begin
                done <= 1'b1;
                if (br_now)
                    next_pc <= br_target;
                else if (rec_vld)
                    next_pc <= rec_tgt;
                else
                    next_pc <= fallthru;
            end
        end
    end

    // Completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // Redirect address moves only when the block completes
    assert_pc_only_on_done_R9: assert property (@(posedge clk) disable iff (rst)
        !done |=> (done || $stable(next_pc)));

endmodule

// File: rtl/bbs_loop_seq.sv
module bbs_loop_seq #(
    parameter int ADDR_W = 32,
    parameter int NB_W   = 3,
    parameter int LC_W   = 8,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] hdr_base,
    input  logic [NB_W-1:0]   hdr_nb,
    input  logic [1:0]        hdr_lsrc,
    input  logic [LC_W-1:0]   hdr_limm,
    input  logic [RIDX_W-1:0] hdr_lreg,
    output logic [RIDX_W-1:0] rf_idx,
    input  logic [LC_W-1:0]   rf_data,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    output logic              busy,
    output logic              bundle_valid,
    output logic [ADDR_W-1:0] bundle_addr,
    output logic [NB_W-1:0]   bundle_idx,
    output logic [LC_W-1:0]   iter_num,
    output logic              block_done,
    output logic [ADDR_W-1:0] next_pc
);
    import bbs_pkg::*;

    seq_flags_t        flags;
    logic              accept;
    logic [NB_W-1:0]   nb_eff;
    logic [LC_W-1:0]   trips;
    logic [ADDR_W-1:0] base_r;
    logic [ADDR_W-1:0] fallthru_r;

    assign rf_idx = hdr_lreg;
    assign accept = start && !flags.running;
    assign nb_eff = (hdr_nb == '0) ? NB_W'(1) : hdr_nb;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_r     <= '0;
            fallthru_r <= '0;
        end else if (accept) begin
            base_r     <= hdr_base;
            fallthru_r <= hdr_base + ADDR_W'(nb_eff);
        end
    end

    bbs_trip_sel #(.LC_W(LC_W)) u_trip (
        .lsrc  (hdr_lsrc),
        .limm  (hdr_limm),
        .rdata (rf_data),
        .trips (trips)
    );

    bbs_iter_ctrl #(.NB_W(NB_W), .LC_W(LC_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .nb_eff (nb_eff),
        .trips  (trips),
        .idx    (bundle_idx),
        .iter   (iter_num),
        .flags  (flags)
    );

    bbs_redirect #(.ADDR_W(ADDR_W)) u_redir (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .issue       (flags.running),
        .last_bundle (flags.last_bundle),
        .last_iter   (flags.last_iter),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .fallthru    (fallthru_r),
        .done        (block_done),
        .next_pc     (next_pc)
    );

    assign busy         = flags.running;
    assign bundle_valid = flags.running;
    assign bundle_addr  = base_r + ADDR_W'(bundle_idx);

    // A header offered while busy leaves the captured block untouched
    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(base_r) && $stable(fallthru_r)));

    // Completion never overlaps issue and follows an issuing cycle
    assert_done_after_issue_R8: assert property (@(posedge clk) disable iff (rst)
        block_done |-> (!bundle_valid && $past(bundle_valid)));

    // Accepting a header starts issue at bundle 0 of pass 0
    assert_entry_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && bundle_idx == '0 && iter_num == '0));

endmodule

// File: tb/sim_bbs_loop_seq.sv
module sim_bbs_loop_seq;

    localparam int ADDR_W = 32;
    localparam int NB_W   = 3;
    localparam int LC_W   = 8;
    localparam int RIDX_W = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [ADDR_W-1:0] hdr_base;
    logic [NB_W-1:0]   hdr_nb;
    logic [1:0]        hdr_lsrc;
    logic [LC_W-1:0]   hdr_limm;
    logic [RIDX_W-1:0] hdr_lreg;
    logic [RIDX_W-1:0] rf_idx;
    logic [LC_W-1:0]   rf_data;
    logic              br_taken;
    logic [ADDR_W-1:0] br_target;
    logic              busy;
    logic              bundle_valid;
    logic [ADDR_W-1:0] bundle_addr;
    logic [NB_W-1:0]   bundle_idx;
    logic [LC_W-1:0]   iter_num;
    logic              block_done;
    logic [ADDR_W-1:0] next_pc;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bbs_loop_seq #(.ADDR_W(ADDR_W), .NB_W(NB_W), .LC_W(LC_W), .RIDX_W(RIDX_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .hdr_base(hdr_base), .hdr_nb(hdr_nb),
        .hdr_lsrc(hdr_lsrc), .hdr_limm(hdr_limm), .hdr_lreg(hdr_lreg), .rf_idx(rf_idx),
        .rf_data(rf_data), .br_taken(br_taken), .br_target(br_target), .busy(busy),
        .bundle_valid(bundle_valid), .bundle_addr(bundle_addr), .bundle_idx(bundle_idx),
        .iter_num(iter_num), .block_done(block_done), .next_pc(next_pc)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one block and checks issue order, completion and redirect.
    // Branch positions use pass/bundle; a pass of -1 means no branch.
    task automatic exec_block(
        input string req, input int base, input int nbf, input int src, input int imm,
        input int rfv, input int exp_trips,
        input int b1_it, input int b1_ix, input int t1,
        input int b2_it, input int b2_ix, input int t2,
        input bit poke_start);
        int nbe;
        int errs;
        int cnt;
        int exp_pc;
        int lastix;
        nbe = (nbf == 0) ? 1 : nbf;
        errs = 0;
        cnt = 0;
        exp_pc = base + nbe;
        lastix = -1;
        if (b1_it == exp_trips - 1) begin exp_pc = t1; lastix = b1_ix; end
        if (b2_it == exp_trips - 1 && b2_ix > lastix) exp_pc = t2;
        @(negedge clk);
        hdr_base = base; hdr_nb = nbf; hdr_lsrc = src; hdr_limm = imm;
        hdr_lreg = 5'd9; rf_data = rfv; start = 1;
        #1;
        check(rf_idx == 5'd9, {req, " R5 rf_idx"}, rf_idx, 9);
        @(negedge clk);
        start = 0;
        rf_data = 8'd200;
        for (int it = 0; it < exp_trips; it++) begin
            for (int ix = 0; ix < nbe; ix++) begin
                if (!(bundle_valid && busy && bundle_addr == base + ix &&
                      bundle_idx == ix && iter_num == it)) errs++;
                cnt++;
                br_taken = ((it == b1_it && ix == b1_ix) || (it == b2_it && ix == b2_ix));
                br_target = (it == b2_it && ix == b2_ix) ? t2 : t1;
                if (poke_start && it == 0 && ix == 0) begin
                    start = 1; hdr_base = 32'hDEAD0; hdr_nb = 3'd7; hdr_lsrc = 2'd1;
                    hdr_limm = 8'd9;
                end
                @(negedge clk);
                start = 0;
                br_taken = 0;
            end
        end
        check(errs == 0, {req, " R2 R6 R7 sequence"}, errs, 0);
        check(cnt == nbe * exp_trips, {req, " R6 bundle count"}, cnt, nbe * exp_trips);
        check(block_done == 1 && busy == 0 && bundle_valid == 0, {req, " R8 done"},
              {block_done, busy, bundle_valid}, 3'b100);
        check(next_pc == exp_pc, {req, " R8 R9 next_pc"}, next_pc, exp_pc);
        @(negedge clk);
        check(block_done == 0, {req, " R8 single pulse"}, block_done, 0);
    endtask

    task automatic t_reset();
        rst = 1; start = 0; hdr_base = 0; hdr_nb = 0; hdr_lsrc = 0; hdr_limm = 0;
        hdr_lreg = 0; rf_data = 0; br_taken = 0; br_target = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check(!busy && !bundle_valid && !block_done, "R11 reset flags",
              {busy, bundle_valid, block_done}, 0);
        check(next_pc == 0, "R11 reset next_pc", next_pc, 0);
    endtask

    task automatic t_single_pass();
        exec_block("R1 single", 32'h100, 3, 0, 0, 0, 1, -1, 0, 0, -1, 0, 0, 0);
    endtask

    task automatic t_imm_loop_early_branch();
        exec_block("R6 R9 early branch", 32'h200, 2, 1, 4, 0, 4, 1, 0, 32'h7000, -1, 0, 0, 0);
    endtask

    task automatic t_branch_first_bundle();
        exec_block("R7 branch bundle0", 32'h300, 4, 1, 3, 0, 3, 2, 0, 32'h8000, -1, 0, 0, 0);
    endtask

    task automatic t_two_branches();
        exec_block("R9 latest wins", 32'h400, 4, 1, 2, 0, 2, 1, 1, 32'h9100, 1, 3, 32'h9300, 0);
    endtask

    task automatic t_reg_count();
        exec_block("R3 R5 reg count", 32'h500, 2, 2, 50, 5, 5, -1, 0, 0, -1, 0, 0, 0);
    endtask

    task automatic t_count_zero_one();
        exec_block("R4 imm zero", 32'h600, 3, 1, 0, 0, 1, -1, 0, 0, -1, 0, 0, 0);
        exec_block("R4 imm one", 32'h640, 3, 1, 1, 0, 1, 0, 2, 32'hA000, -1, 0, 0, 0);
    endtask

    task automatic t_rsvd_src();
        exec_block("R3 src3", 32'h700, 2, 3, 6, 6, 1, -1, 0, 0, -1, 0, 0, 0);
    endtask

    task automatic t_nb_zero();
        exec_block("R2 nb zero", 32'h800, 0, 1, 2, 0, 2, -1, 0, 0, -1, 0, 0, 0);
    endtask

    task automatic t_start_while_busy();
        exec_block("R10 busy start", 32'h900, 3, 1, 2, 0, 2, -1, 0, 0, -1, 0, 0, 1);
    endtask

    task automatic t_idle_branch();
        @(negedge clk);
        br_taken = 1; br_target = 32'hBBBB;
        @(negedge clk);
        br_taken = 0;
        exec_block("R9 idle branch", 32'hA00, 1, 0, 0, 0, 1, -1, 0, 0, -1, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_single_pass();
        t_imm_loop_early_branch();
        t_branch_first_bundle();
        t_two_branches();
        t_reg_count();
        t_count_zero_one();
        t_rsvd_src();
        t_nb_zero();
        t_start_while_busy();
        t_idle_branch();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule